// File: doc/BRIEF.md
# Fractional-Rate PCM Decimator (3.579545 MHz to 48 kHz)

This block takes a stereo PCM stream produced at 3.579545 MHz by sound generator models and a mixer, and turns it into 48 kHz samples, 20 bits wide, for a codec serializer. Everything runs on a single 24.576 MHz clock. The block makes its own 3.579545 MHz sample strobe from that clock with an exact fractional phase accumulator, and it gives the strobe to the upstream sources. Their pace therefore comes from the audio reference and never from a host CPU clock.

Each input sample is held until the next one arrives, which turns the stream into a 24.576 MHz stepped signal. A third-order cascaded integrator-comb (CIC) low-pass stage runs at that rate. Its combs are sampled on a 48 kHz strobe that falls exactly every 512 clocks, so the decimation ratio is a whole power of two even though the input rate ratio is not. A 7-tap symmetric FIR then shapes the band, rounds the result to 20 bits and saturates it. The CIC gives a gain of exactly one at DC, so the path as a whole carries a DC level through unchanged, only scaled to the wider output word.

Top module: `pcm_decim48`

## Requirements
- R1: `src_tick` is a one-cycle pulse. Successive pulses are 6 or 7 clocks apart, and exactly 3579 pulses come out in the first 24576 clocks after reset is released (3579545/24576000 of the clock rate, with no long-term drift).
- R2: `out_valid` pulses come exactly 512 clocks apart once the output is running.
- R3: After reset is released, `out_valid` stays low until the 10th 48 kHz output period (3 CIC stages plus 7 FIR taps). The first pulse comes about 10×512+3 clocks after release.
- R4: A constant input held long enough gives an output equal to the input multiplied by 16 (shifted left by 4 into the 20-bit word). This holds at both full-scale ends.
- R5: An input that alternates between +30000 and −30000 on each input sample (about 1.79 MHz) is attenuated to less than 16384 in magnitude at the output. That is more than 30 dB below full scale.
- R6: Filter overshoot beyond the 20-bit range is clipped to +524287 or −524288. There is no wrap-around.
- R7: While `rst` is high, `out_valid` is 0 and both outputs read 0. Reset clears every filter register, so after release a zero input gives a first output of exactly 0.
- R8: The left and right channels are independent. A constant on one channel gives its exact R4 value whatever the other channel carries.
- R9: Input samples presented while `in_valid` is low are ignored. The output keeps the level of the last sample accepted with `in_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz audio reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | output | 1 | 3.579545 MHz sample strobe for the upstream sources |
| in_valid | input | 1 | Input sample strobe; the samples are taken when it is high |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| out_valid | output | 1 | One-cycle strobe at 48 kHz marking new output samples |
| out_left | output | 20 | Left output sample, signed |
| out_right | output | 20 | Right output sample, signed |

## Verification
The chain is driven with constant levels, both directed full-scale values and seeded random values. These show whether the DC gain and the rounding are exact, and whether the CIC scaling shift is right. An alternating input near the top of the input rate separates a working low-pass from one whose comb or integrator ordering is broken. Hard steps between the two full-scale ends make the negative FIR taps overshoot, which shows whether the output clips or wraps. Holding `in_valid` low while the samples change, and running different signals on the two channels, shows that the hold register and the channels stay isolated.

// File: rtl/pcm_decim_pkg.sv
package pcm_decim_pkg;

  // Band-shaping FIR: odd length, symmetric, coefficients sum to 2**COEF_SH.
  localparam int FIR_TAPS = 7;
  localparam int COEF_SH  = 5;

  function automatic int fir_coef(input int idx);
    case (idx)
      0, 6:    return -1;
      2, 4:    return 9;
      3:       return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/phase_tick.sv
// Fractional-rate strobe: adds STEP per clock modulo MODULUS and pulses on each wrap.
module phase_tick #(
  parameter int unsigned STEP    = 48000,
  parameter int unsigned MODULUS = 24576000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int AW = $clog2(MODULUS) + 1;
  localparam int LO = MODULUS / STEP;
  localparam int HI = (MODULUS + STEP - 1) / STEP;
  localparam int GW = $clog2(HI + 1) + 1;

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  assign sum = acc + AW'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (sum >= AW'(MODULUS)) begin
      acc  <= sum - AW'(MODULUS);
      tick <= 1'b1;
    end else begin
      acc  <= sum;
      tick <= 1'b0;
    end
  end

  // Spacing monitor for the assertions below.
  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  // R1, R2: pulses come floor or ceil of MODULUS/STEP clocks apart
  a_r1_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && seen) |-> (gap == GW'(LO - 1) || gap == GW'(HI - 1)));

  generate
    if (2 * STEP <= MODULUS) begin : g_single
      // R1: a pulse never lasts two cycles
      a_r1_one_cycle_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/cic_decim.sv
// Zero-order-hold upsample into an N-stage CIC; combs sampled on each dump strobe.
module cic_decim #(
  parameter int IN_W = 16,
  parameter int N    = 3,
  parameter int RLOG = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_en,
  input  logic signed [IN_W-1:0] din,
  input  logic                   dump,
  output logic signed [IN_W-1:0] dout,
  output logic                   dout_vld
);
  localparam int GROW = N * RLOG;
  localparam int W    = IN_W + GROW;

  logic signed [IN_W-1:0] hold;
  logic signed [W-1:0]    integ [N];
  logic signed [W-1:0]    dly   [N];
  logic signed [W-1:0]    diff  [N+1];

  always_ff @(posedge clk) begin
    if (rst)         hold <= '0;
    else if (smp_en) hold <= din;
  end

  generate
    for (genvar k = 0; k < N; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) integ[k] <= '0;
          else     integ[k] <= integ[k] + {{GROW{hold[IN_W-1]}}, hold};
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) integ[k] <= '0;
          else     integ[k] <= integ[k] + integ[k-1];
        end
      end

      assign diff[k+1] = diff[k] - dly[k];

      always_ff @(posedge clk) begin
        if (rst)       dly[k] <= '0;
        else if (dump) dly[k] <= diff[k];
      end
    end
  endgenerate

  assign diff[0] = integ[N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= dump;
      if (dump) dout <= IN_W'(diff[N] >>> GROW);
    end
  end

  // R9: the held sample only moves on an accepted strobe
  a_r9_hold_kept: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(hold));

endmodule

// File: rtl/fir_sym.sv
// Symmetric FIR with pre-added tap pairs, rounding, saturation and a fill gate.
module fir_sym
  import pcm_decim_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 20,
  parameter int FILL  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    din_vld,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout,
  output logic                    dout_vld
);
  localparam int T   = FIR_TAPS;
  localparam int H   = T / 2;
  localparam int AW  = IN_W + OUT_W;
  localparam int SH  = COEF_SH - (OUT_W - IN_W);
  localparam int LSH = (SH < 0) ? -SH : 0;
  localparam int CW  = $clog2(FILL + 1);
  localparam logic signed [AW-1:0] HI_L = (AW'(1) <<< (OUT_W - 1)) - AW'(1);
  localparam logic signed [AW-1:0] LO_L = -HI_L - AW'(1);

  logic signed [IN_W-1:0] line [T];
  logic signed [AW-1:0]   part [H+1];
  logic signed [AW-1:0]   acc;
  logic signed [AW-1:0]   rnd;
  logic                   calc_go;
  logic [CW-1:0]          cnt;
  logic                   full;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < T; i++) line[i] <= '0;
    end else if (din_vld) begin
      line[0] <= din;
      for (int i = 1; i < T; i++) line[i] <= line[i-1];
    end
  end

  generate
    for (genvar i = 0; i < H; i++) begin : g_pair
      assign part[i] = (AW'(line[i]) + AW'(line[T-1-i])) * AW'(fir_coef(i));
    end
  endgenerate
  assign part[H] = AW'(line[H]) * AW'(fir_coef(H));

  always_comb begin
    acc = '0;
    for (int i = 0; i <= H; i++) acc = acc + part[i];
  end

  generate
    if (SH > 0) begin : g_round
      assign rnd = (acc + (AW'(1) <<< (SH - 1))) >>> SH;
    end else begin : g_widen
      assign rnd = acc <<< LSH;
    end
  endgenerate

  assign full = (cnt == CW'(FILL));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      calc_go  <= 1'b0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      calc_go  <= din_vld;
      dout_vld <= calc_go && full;
      if (din_vld && !full) cnt <= cnt + 1'b1;
      if (calc_go && full) begin
        if (rnd > HI_L)      dout <= OUT_W'(HI_L);
        else if (rnd < LO_L) dout <= OUT_W'(LO_L);
        else                 dout <= OUT_W'(rnd);
      end
    end
  end

  // R6: an out-of-range result lands on the matching rail
  a_r6_clip_high: assert property (@(posedge clk) disable iff (rst)
    (calc_go && full && rnd > HI_L) |=> (dout == OUT_W'(HI_L)));
  a_r6_clip_low: assert property (@(posedge clk) disable iff (rst)
    (calc_go && full && rnd < LO_L) |=> (dout == OUT_W'(LO_L)));

endmodule

// File: rtl/pcm_decim48.sv
module pcm_decim48
  import pcm_decim_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 20,
  parameter int CLK_HZ = 24576000,
  parameter int SRC_HZ = 3579545,
  parameter int OUT_HZ = 48000,
  parameter int CIC_N  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    src_tick,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_left,
  input  logic signed [IN_W-1:0]  in_right,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_left,
  output logic signed [OUT_W-1:0] out_right
);
  localparam int RATIO = CLK_HZ / OUT_HZ;
  localparam int RLOG  = $clog2(RATIO);
  localparam int FILL  = CIC_N + FIR_TAPS;
  localparam int NCH   = 2;

  logic dump;
  logic signed [IN_W-1:0]  ch_in   [NCH];
  logic signed [IN_W-1:0]  cic_out [NCH];
  logic                    cic_vld [NCH];
  logic signed [OUT_W-1:0] fir_out [NCH];
  logic                    fir_vld [NCH];

  phase_tick #(.STEP(SRC_HZ), .MODULUS(CLK_HZ)) u_src_rate (
    .clk(clk), .rst(rst), .tick(src_tick)
  );

  phase_tick #(.STEP(OUT_HZ), .MODULUS(CLK_HZ)) u_out_rate (
    .clk(clk), .rst(rst), .tick(dump)
  );

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      cic_decim #(.IN_W(IN_W), .N(CIC_N), .RLOG(RLOG)) u_cic (
        .clk(clk), .rst(rst), .smp_en(in_valid), .din(ch_in[c]),
        .dump(dump), .dout(cic_out[c]), .dout_vld(cic_vld[c])
      );
      fir_sym #(.IN_W(IN_W), .OUT_W(OUT_W), .FILL(FILL)) u_fir (
        .clk(clk), .rst(rst), .din_vld(cic_vld[c]), .din(cic_out[c]),
        .dout(fir_out[c]), .dout_vld(fir_vld[c])
      );
    end
  endgenerate

  assign out_left  = fir_out[0];
  assign out_right = fir_out[1];
  assign out_valid = fir_vld[0] & fir_vld[1];

  // R3: no valid output in the first cycle after reset
  a_r3_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/sim_pcm_decim48.sv
module sim_pcm_decim48;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic feed_en = 1'b1;
  logic alt_mode = 1'b0;
  logic signed [15:0] drv_left = '0, drv_right = '0, alt_val = 16'sd30000;
  logic signed [15:0] in_left, in_right;
  logic src_tick, in_valid, out_valid;
  logic signed [19:0] out_left, out_right;

  int errs = 0, checks = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign in_valid = src_tick & feed_en;
  assign in_left  = alt_mode ? alt_val : drv_left;
  assign in_right = drv_right;

  pcm_decim48 u0 (
    .clk(clk), .rst(rst), .src_tick(src_tick), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  always @(negedge clk) if (alt_mode && src_tick) alt_val <= -alt_val;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 195000 && !done) begin
      errs = errs + 1; checks = checks + 1;
      $display("FAIL watchdog (all requirements): act=%0d exp<=195000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic int dc_out(input int v);
    return v * 16;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errs = errs + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_out(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!out_valid) @(negedge clk);
    end
  endtask

  // Release reset at a negedge and return cycles until the first out_valid.
  task automatic release_and_time(output int first);
    first = -1;
    rst = 1'b0;
    for (int i = 1; i < 6000 && first < 0; i++) begin
      @(negedge clk);
      if (out_valid) first = i;
    end
  endtask

  initial begin
    int ticks, last, gmin, gmax, first, t0, lvl_l, lvl_r, mx, mn, hfmax, rbad, seed;
    seed = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    // R7: reset state
    check(out_valid == 1'b0 && out_left == 0 && out_right == 0, "R7 reset outputs",
          int'(out_left), 0);

    // R1 and R3 from the same run after release
    rst = 1'b0;
    ticks = 0; last = -1; gmin = 1000; gmax = 0; first = -1;
    for (int i = 1; i <= 24576; i++) begin
      @(negedge clk);
      if (src_tick) begin
        ticks++;
        if (last >= 0) begin
          if (i - last < gmin) gmin = i - last;
          if (i - last > gmax) gmax = i - last;
        end
        last = i;
      end
      if (out_valid && first < 0) first = i;
    end
    check(ticks == 3579, "R1 tick count", ticks, 3579);
    check(gmin == 6 && gmax == 7, "R1 tick spacing", gmin * 100 + gmax, 607);
    check(first >= 5115 && first <= 5135, "R3 first valid", first, 5123);

    // R2: output period
    wait_out(1);
    t0 = cyc;
    for (int k = 0; k < 4; k++) begin
      wait_out(1);
      check(cyc - t0 == 512, "R2 output period", cyc - t0, 512);
      t0 = cyc;
    end

    // R4, R8: DC levels, directed extremes then seeded random
    for (int k = 0; k < 5; k++) begin
      if (k == 0) begin lvl_l = 32767; lvl_r = -32768; end
      else begin
        lvl_l = int'($signed(16'($urandom())));
        lvl_r = int'($signed(16'($urandom())));
      end
      drv_left = 16'(lvl_l); drv_right = 16'(lvl_r);
      wait_out(14);
      check(out_left == 20'(dc_out(lvl_l)), "R4 DC left", int'(out_left), dc_out(lvl_l));
      check(out_right == 20'(dc_out(lvl_r)), "R8 DC right", int'(out_right), dc_out(lvl_r));
    end

    // R9: samples without in_valid are ignored
    feed_en = 1'b0;
    drv_left = 16'(-lvl_l - 1); drv_right = 16'sd100;
    wait_out(14);
    check(out_left == 20'(dc_out(lvl_l)), "R9 ignored left", int'(out_left), dc_out(lvl_l));
    check(out_right == 20'(dc_out(lvl_r)), "R9 ignored right", int'(out_right), dc_out(lvl_r));
    feed_en = 1'b1;

    // R5 with R8: alternating left, constant right
    alt_mode = 1'b1; drv_right = 16'sd12345;
    wait_out(14);
    hfmax = 0; rbad = 0;
    for (int k = 0; k < 20; k++) begin
      wait_out(1);
      if ((out_left < 0 ? -int'(out_left) : int'(out_left)) > hfmax)
        hfmax = (out_left < 0) ? -int'(out_left) : int'(out_left);
      if (out_right != 20'(dc_out(12345))) rbad++;
    end
    check(hfmax < 16384, "R5 alternating rejection", hfmax, 16383);
    check(rbad == 0, "R8 right undisturbed", rbad, 0);
    alt_mode = 1'b0;

    // R6: full-scale steps clip
    drv_left = -16'sd32768;
    wait_out(14);
    drv_left = 16'sd32767;
    mx = -1000000;
    for (int k = 0; k < 14; k++) begin
      wait_out(1);
      if (int'(out_left) > mx) mx = int'(out_left);
    end
    check(mx == 524287, "R6 clip high", mx, 524287);
    check(out_left == 20'(dc_out(32767)), "R6 settle after clip", int'(out_left), dc_out(32767));
    drv_left = -16'sd32768;
    mn = 1000000;
    for (int k = 0; k < 14; k++) begin
      wait_out(1);
      if (int'(out_left) < mn) mn = int'(out_left);
    end
    check(mn == -524288, "R6 clip low", mn, -524288);

    // R7: mid-run reset clears state
    drv_left = 16'sd20000; drv_right = -16'sd20000;
    wait_out(14);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_left == 0 && out_right == 0, "R7 outputs in reset",
          int'(out_left), 0);
    drv_left = '0; drv_right = '0;
    release_and_time(first);
    check(first >= 5115 && first <= 5135, "R3 first valid after reset", first, 5123);
    check(out_left == 0 && out_right == 0, "R7 state cleared", int'(out_left), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule